// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block is the digital controller that sits in front of an eight-channel successive-approximation converter core. Software programs a first and a last channel, a trigger source, a sample duration and a result alignment through a small 16-bit register bus. When the selected trigger fires, the sequencer walks the channels in ascending order. For each channel it holds the channel select steady, asserts a sample enable for the programmed number of cycles and then pulses a start strobe. It waits for the core's done strobe and captures the 10-bit result into a 16-bit result word.

A single scan stops after the last channel. A continuous scan wraps back to the first channel and keeps going until software clears the continuous bit, after which it finishes at the last channel. A status word shows a busy indication and a sticky conversion-complete flag that software clears by writing 1. The trigger can come from a software strobe, a timer event or an active-low external pin. The pin is synchronized and acts on its falling edge.

Top module: `adc_scan_seq`

## Requirements
- R1: The configuration word (address 1) holds first channel in bits 2:0, last channel in bits 5:3, continuous bit in bit 6, trigger source in bits 8:7, sample code in bits 11:9 and left-align bit in bit 12. Bits 15:13 always read 0. After reset the word reads 0x0E00, so the sample code resets to 7.
- R2: The result word (address 0) reads 0 after reset and ignores bus writes. With the left-align bit at 0 it holds the 10-bit result in bits 9:0 with bits 15:10 at 0.
- R3: With the left-align bit at 1 the result word holds the 10-bit result in bits 15:6 with bits 5:0 at 0.
- R4: For each channel, the sample enable is high for exactly (sample code + 2) consecutive cycles. The start strobe is then high for exactly one cycle, and the channel select does not change between sampling and start.
- R5: After an accepted trigger, channels from first to last are converted once each in ascending order. The busy output rises on the clock edge that accepts the trigger and falls on the edge that stores the last channel's result.
- R6: When the last channel is lower than the first channel, only the first channel is converted.
- R7: With the continuous bit set, the scan returns to the first channel after the last one. When the bit is cleared mid-scan, the scan stops after the next conversion of the last channel.
- R8: Trigger source code 0 selects the software strobe, 1 the timer event, 2 nothing, and 3 a falling edge of the external pin. The pin passes two synchronizer flops and an edge detector, so busy rises on the third clock edge after the pin falls. A rising pin edge does nothing.
- R9: A trigger that arrives while busy is high is ignored and does not lengthen or restart the scan.
- R10: The status word (address 2) shows the conversion-complete flag in bit 0 and busy in bit 1. The flag sets on every stored result and clears when 1 is written to bit 0 of address 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register word select |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data (combinational from bus_addr) |
| sw_trig | input | 1 | Software trigger strobe |
| tmr_trig | input | 1 | Timer event trigger strobe |
| ext_trig_n | input | 1 | Asynchronous external trigger pin, active on falling edge |
| conv_ch | output | 3 | Channel select to the converter core |
| conv_sample | output | 1 | Sample enable to the converter core |
| conv_start | output | 1 | One-cycle conversion start strobe |
| conv_done | input | 1 | One-cycle conversion done strobe from the core |
| conv_result | input | 10 | Conversion result, valid with conv_done |
| busy | output | 1 | Scan in progress |
| done_flag | output | 1 | Sticky conversion-complete flag |

## Verification
A software or timer trigger seen at one clock edge raises busy and the sample enable right after that edge. A falling pin edge raises busy only after the third edge, so the bench checks busy still low two cycles after the pin falls and high one cycle later. The stubbed core counts sample-enable cycles up to the start strobe and logs the channel. It answers three cycles later with a result that is a known function of the channel. Result, flag and busy are read only after busy has fallen, on the falling clock edge, when the storing edge has already passed.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CH_W      = 3;
    localparam int RES_W     = 10;
    localparam int WORD_W    = 16;
    localparam int SMP_W     = 3;
    localparam int ADDR_W    = 2;
    localparam int SMP_EXTRA = 2;
    localparam int CNT_W     = SMP_W + 1;

    localparam logic [ADDR_W-1:0] A_RESULT = 2'd0;
    localparam logic [ADDR_W-1:0] A_CONFIG = 2'd1;
    localparam logic [ADDR_W-1:0] A_STATUS = 2'd2;

    localparam int ST_FLAG_BIT = 0;

    typedef enum logic [1:0] {
        TSRC_SOFT  = 2'd0,
        TSRC_TIMER = 2'd1,
        TSRC_NONE  = 2'd2,
        TSRC_PIN   = 2'd3
    } tsrc_e;

    // Packed MSB first: left(12) smp(11:9) tsel(8:7) cont(6) last(5:3) first(2:0)
    typedef struct packed {
        logic             left;
        logic [SMP_W-1:0] smp;
        tsrc_e            tsel;
        logic             cont;
        logic [CH_W-1:0]  last;
        logic [CH_W-1:0]  first;
    } cfg_t;

    localparam int CF_W = $bits(cfg_t);

    localparam cfg_t CFG_RST = '{left: 1'b0, smp: '1, tsel: TSRC_SOFT,
                                 cont: 1'b0, last: '0, first: '0};

    typedef enum logic [1:0] {
        S_IDLE,
        S_SAMPLE,
        S_START,
        S_WAIT
    } seq_state_e;

    function automatic logic [WORD_W-1:0] place_result(input logic [RES_W-1:0] r,
                                                       input logic left);
        if (left)
            return {r, {(WORD_W-RES_W){1'b0}}};
        else
            return {{(WORD_W-RES_W){1'b0}}, r};
    endfunction

    function automatic logic [CH_W-1:0] scan_last(input logic [CH_W-1:0] first,
                                                  input logic [CH_W-1:0] last);
        return (last < first) ? first : last;
    endfunction

endpackage

// File: rtl/adc_seq_trig.sv
module adc_seq_trig
    import adc_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  tsrc_e sel,
    input  logic  sw_trig,
    input  logic  tmr_trig,
    input  logic  ext_pin_n,
    output logic  trig_evt
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   pin_prev;
    logic                   pin_fall;

    // Reset to the idle-high level so no false edge appears after reset
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q   <= '1;
            pin_prev <= 1'b1;
        end else begin
            sync_q   <= {sync_q[SYNC_STAGES-2:0], ext_pin_n};
            pin_prev <= sync_q[SYNC_STAGES-1];
        end
    end

    assign pin_fall = pin_prev & ~sync_q[SYNC_STAGES-1];

    always_comb begin
        unique case (sel)
            TSRC_SOFT:  trig_evt = sw_trig;
            TSRC_TIMER: trig_evt = tmr_trig;
            TSRC_PIN:   trig_evt = pin_fall;
            default:    trig_evt = 1'b0;
        endcase
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CH_W-1:0]  first_ch,
    input  logic [CH_W-1:0]  last_ch,
    input  logic [SMP_W-1:0] smp_code,
    input  logic             cont,
    input  logic             trig_evt,
    input  logic             conv_done,
    output logic [CH_W-1:0]  conv_ch,
    output logic             conv_sample,
    output logic             conv_start,
    output logic             busy,
    output logic             store_en
);

    seq_state_e       state;
    logic [CH_W-1:0]  ch_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_load;
    logic [CH_W-1:0]  stop_ch;

    assign cnt_load = {1'b0, smp_code} + CNT_W'(SMP_EXTRA - 1);
    assign stop_ch  = scan_last(first_ch, last_ch);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            ch_q  <= '0;
            cnt_q <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (trig_evt) begin
                        ch_q  <= first_ch;
                        cnt_q <= cnt_load;
                        state <= S_SAMPLE;
                    end
                end
                S_SAMPLE: begin
                    if (cnt_q == '0)
                        state <= S_START;
                    else
                        cnt_q <= cnt_q - 1'b1;
                end
                S_START: begin
                    state <= S_WAIT;
                end
                S_WAIT: begin
                    if (conv_done) begin
                        if (ch_q >= stop_ch) begin
                            if (cont) begin
                                ch_q  <= first_ch;
                                cnt_q <= cnt_load;
                                state <= S_SAMPLE;
                            end else begin
                                state <= S_IDLE;
                            end
                        end else begin
                            ch_q  <= ch_q + 1'b1;
                            cnt_q <= cnt_load;
                            state <= S_SAMPLE;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign conv_ch     = ch_q;
    assign conv_sample = (state == S_SAMPLE);
    assign conv_start  = (state == S_START);
    assign busy        = (state != S_IDLE);
    assign store_en    = (state == S_WAIT) && conv_done;

endmodule

// File: rtl/adc_seq_result.sv
module adc_seq_result
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              store_en,
    input  logic [RES_W-1:0]  conv_result,
    input  logic              left,
    input  logic              flag_clr,
    output logic [WORD_W-1:0] result_word,
    output logic              done_flag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            result_word <= '0;
            done_flag   <= 1'b0;
        end else begin
            if (store_en)
                result_word <= place_result(conv_result, left);
            // a new result wins over a clear in the same cycle
            if (store_en)
                done_flag <= 1'b1;
            else if (flag_clr)
                done_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic [WORD_W-1:0] result_word,
    input  logic              busy,
    input  logic              done_flag,
    output cfg_t              cfg,
    output logic              flag_clr,
    output logic [WORD_W-1:0] bus_rdata
);

    logic [WORD_W-CF_W-1:0] unused_wbits;
    logic [CF_W-1:0]        wr_cfg;

    assign {unused_wbits, wr_cfg} = bus_wdata;

    always_ff @(posedge clk) begin
        if (rst)
            cfg <= CFG_RST;
        else if (bus_we && bus_addr == A_CONFIG)
            cfg <= cfg_t'(wr_cfg);
    end

    assign flag_clr = bus_we && (bus_addr == A_STATUS) && wr_cfg[ST_FLAG_BIT];

    always_comb begin
        unique case (bus_addr)
            A_RESULT: bus_rdata = result_word;
            A_CONFIG: bus_rdata = {{(WORD_W-CF_W){1'b0}}, cfg};
            A_STATUS: bus_rdata = {{(WORD_W-2){1'b0}}, busy, done_flag};
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              sw_trig,
    input  logic              tmr_trig,
    input  logic              ext_trig_n,
    output logic [CH_W-1:0]   conv_ch,
    output logic              conv_sample,
    output logic              conv_start,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result,
    output logic              busy,
    output logic              done_flag
);

    cfg_t              cfg;
    logic              flag_clr;
    logic              trig_evt;
    logic              store_en;
    logic [WORD_W-1:0] result_word;

    adc_seq_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_addr    (bus_addr),
        .bus_we      (bus_we),
        .bus_wdata   (bus_wdata),
        .result_word (result_word),
        .busy        (busy),
        .done_flag   (done_flag),
        .cfg         (cfg),
        .flag_clr    (flag_clr),
        .bus_rdata   (bus_rdata)
    );

    adc_seq_trig #(.SYNC_STAGES(2)) u_trig (
        .clk       (clk),
        .rst       (rst),
        .sel       (cfg.tsel),
        .sw_trig   (sw_trig),
        .tmr_trig  (tmr_trig),
        .ext_pin_n (ext_trig_n),
        .trig_evt  (trig_evt)
    );

    adc_seq_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .first_ch    (cfg.first),
        .last_ch     (cfg.last),
        .smp_code    (cfg.smp),
        .cont        (cfg.cont),
        .trig_evt    (trig_evt),
        .conv_done   (conv_done),
        .conv_ch     (conv_ch),
        .conv_sample (conv_sample),
        .conv_start  (conv_start),
        .busy        (busy),
        .store_en    (store_en)
    );

    adc_seq_result u_result (
        .clk         (clk),
        .rst         (rst),
        .store_en    (store_en),
        .conv_result (conv_result),
        .left        (cfg.left),
        .flag_clr    (flag_clr),
        .result_word (result_word),
        .done_flag   (done_flag)
    );

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] conv_ch,
    input logic       conv_sample,
    input logic       conv_start,
    input logic       conv_done,
    input logic       busy,
    input logic       done_flag
);

    AST_SAMPLE_IN_SCAN: assert property (@(posedge clk) disable iff (rst)
        conv_sample |-> busy); // R5

    AST_NO_START_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !conv_start); // R5

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start); // R4

    AST_START_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> $past(conv_sample)); // R4

    AST_SAMPLE_MIN_TWO: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_sample) |=> conv_sample); // R4

    AST_CH_HELD: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> $stable(conv_ch)); // R4

    AST_FLAG_FROM_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(done_flag) |-> $past(conv_done)); // R10

endmodule

bind adc_scan_seq adc_scan_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .conv_ch     (conv_ch),
    .conv_sample (conv_sample),
    .conv_start  (conv_start),
    .conv_done   (conv_done),
    .busy        (busy),
    .done_flag   (done_flag)
);

// File: tb/adc_scan_seq_bench.sv
`timescale 1ns/1ps
module adc_scan_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        sw_trig = 1'b0;
    logic        tmr_trig = 1'b0;
    logic        ext_trig_n = 1'b1;
    logic [2:0]  conv_ch;
    logic        conv_sample;
    logic        conv_start;
    logic        conv_done = 1'b0;
    logic [9:0]  conv_result = '0;
    logic        busy;
    logic        done_flag;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    adc_scan_seq u_adc_scan_seq (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sw_trig(sw_trig),
        .tmr_trig(tmr_trig), .ext_trig_n(ext_trig_n), .conv_ch(conv_ch),
        .conv_sample(conv_sample), .conv_start(conv_start),
        .conv_done(conv_done), .conv_result(conv_result),
        .busy(busy), .done_flag(done_flag)
    );

    // ---------------- converter stub ----------------
    int         n_log = 0;
    int         chan_log [64];
    int         samp_log [64];
    int         samp_cnt = 0;
    int         dly = 0;
    logic [9:0] pend_res = '0;

    function automatic logic [9:0] model(input int ch);
        return 10'((ch * 113 + 301) & 10'h3FF);
    endfunction

    always @(negedge clk) begin
        conv_done = 1'b0;
        if (rst) begin
            samp_cnt = 0;
            dly = 0;
        end else begin
            if (conv_sample) samp_cnt++;
            if (dly > 0) begin
                dly--;
                if (dly == 0) begin
                    conv_done   = 1'b1;
                    conv_result = pend_res;
                end
            end
            if (conv_start) begin
                if (n_log < 64) begin
                    chan_log[n_log] = int'(conv_ch);
                    samp_log[n_log] = samp_cnt;
                end
                n_log++;
                samp_cnt = 0;
                pend_res = model(int'(conv_ch));
                dly = 3;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] cfg_word(input int first, input int last,
                                             input int cont, input int tsel,
                                             input int smp, input int left);
        return 16'((left << 12) | (smp << 9) | (tsel << 7) | (cont << 6) |
                   (last << 3) | first);
    endfunction

    task automatic write_reg(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic read_reg(input logic [1:0] a, output int v);
        @(negedge clk);
        bus_addr = a;
        #1 v = int'(bus_rdata);
    endtask

    task automatic pulse_sw();
        @(negedge clk); sw_trig = 1'b1;
        @(negedge clk); sw_trig = 1'b0;
    endtask

    task automatic pulse_tmr();
        @(negedge clk); tmr_trig = 1'b1;
        @(negedge clk); tmr_trig = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        int v;
        read_reg(2'd1, v); check_eq("R1 config reset", v, 16'h0E00);
        read_reg(2'd0, v); check_eq("R2 result reset", v, 0);
        read_reg(2'd2, v); check_eq("R10 status reset", v, 0);
        check_eq("R5 busy reset", int'(busy), 0);
    endtask

    task automatic t_reserved();
        int v;
        write_reg(2'd1, 16'hFFFF);
        read_reg(2'd1, v); check_eq("R1 reserved bits read 0", v, 16'h1FFF);
        write_reg(2'd0, 16'hFFFF);
        read_reg(2'd0, v); check_eq("R2 result ignores write", v, 0);
    endtask

    task automatic t_single();
        int v;
        write_reg(2'd1, cfg_word(2, 5, 0, 0, 3, 0));
        n_log = 0;
        @(negedge clk); sw_trig = 1'b1;
        @(negedge clk); sw_trig = 1'b0;
        check_eq("R5 busy after trigger", int'(busy), 1);
        wait_idle();
        check_eq("R5 count single scan", n_log, 4);
        for (int i = 0; i < 4; i++) begin
            check_eq("R5 ascending channel", chan_log[i], 2 + i);
            check_eq("R4 sample cycles code 3", samp_log[i], 5);
        end
        read_reg(2'd0, v); check_eq("R2 right aligned", v, int'(model(5)));
        read_reg(2'd2, v); check_eq("R10 flag set", v, 1);
        write_reg(2'd2, 16'h0001);
        read_reg(2'd2, v); check_eq("R10 flag cleared", v, 0);
    endtask

    task automatic t_samp();
        write_reg(2'd1, cfg_word(1, 1, 0, 0, 0, 0));
        n_log = 0; pulse_sw(); wait_idle();
        check_eq("R4 sample cycles code 0", samp_log[0], 2);
        write_reg(2'd1, cfg_word(1, 1, 0, 0, 7, 0));
        n_log = 0; pulse_sw(); wait_idle();
        check_eq("R4 sample cycles code 7", samp_log[0], 9);
    endtask

    task automatic t_left();
        int v;
        write_reg(2'd1, cfg_word(6, 6, 0, 0, 1, 1));
        n_log = 0; pulse_sw(); wait_idle();
        read_reg(2'd0, v); check_eq("R3 left aligned", v, int'(model(6)) << 6);
    endtask

    task automatic t_reverse();
        write_reg(2'd1, cfg_word(5, 2, 0, 0, 0, 0));
        n_log = 0; pulse_sw(); wait_idle();
        check_eq("R6 one conversion", n_log, 1);
        check_eq("R6 start channel", chan_log[0], 5);
    endtask

    task automatic t_cont();
        write_reg(2'd1, cfg_word(6, 7, 1, 0, 0, 0));
        n_log = 0; pulse_sw();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (n_log >= 5) break;
        end
        check_eq("R7 still busy in continuous", int'(busy), 1);
        write_reg(2'd1, cfg_word(6, 7, 0, 0, 0, 0));
        wait_idle();
        check_eq("R7 ends on last channel", n_log % 2, 0);
        for (int i = 0; i < n_log && i < 64; i++)
            check_eq("R7 wrap order", chan_log[i], (i % 2 == 1) ? 7 : 6);
    endtask

    task automatic t_busy_ignore();
        write_reg(2'd1, cfg_word(0, 3, 0, 0, 2, 0));
        n_log = 0; pulse_sw();
        idle_cycles(6);
        pulse_sw();
        idle_cycles(15);
        pulse_sw();
        wait_idle();
        idle_cycles(20);
        check_eq("R9 no restart count", n_log, 4);
        check_eq("R9 idle after scan", int'(busy), 0);
    endtask

    task automatic t_trig_sel();
        write_reg(2'd1, cfg_word(3, 3, 0, 1, 0, 0));
        n_log = 0; pulse_sw(); idle_cycles(20);
        check_eq("R8 soft ignored on timer source", n_log, 0);
        pulse_tmr(); wait_idle();
        check_eq("R8 timer trigger", n_log, 1);
        write_reg(2'd1, cfg_word(3, 3, 0, 2, 0, 0));
        n_log = 0; pulse_sw(); pulse_tmr();
        @(negedge clk) ext_trig_n = 1'b0;
        idle_cycles(6);
        @(negedge clk) ext_trig_n = 1'b1;
        idle_cycles(20);
        check_eq("R8 reserved source", n_log, 0);
        write_reg(2'd1, cfg_word(3, 3, 0, 3, 0, 0));
        idle_cycles(5);
        n_log = 0; pulse_tmr(); idle_cycles(10);
        check_eq("R8 timer ignored on pin source", n_log, 0);
        @(negedge clk) ext_trig_n = 1'b0;
        idle_cycles(2);
        check_eq("R8 busy low two cycles after fall", int'(busy), 0);
        idle_cycles(1);
        check_eq("R8 busy high third cycle after fall", int'(busy), 1);
        wait_idle();
        check_eq("R8 pin trigger", n_log, 1);
        @(negedge clk) ext_trig_n = 1'b1;
        idle_cycles(20);
        check_eq("R8 rising edge ignored", n_log, 1);
    endtask

    // ---------------- main ----------------
    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_reserved();
        t_single();
        t_samp();
        t_left();
        t_reverse();
        t_cont();
        t_busy_ignore();
        t_trig_sel();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired before all scenarios finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule